// File: doc/BRIEF.md
# Calendar Alarm Unit

This block watches a running BCD calendar and raises an interrupt when the calendar reaches a programmed moment. Software programs seven alarm bytes through a small register port: seconds, minutes, hours, day of month, month, and a year split into a low and a high BCD byte. It arms the alarm with an enable register. Each second the calendar logic presents the freshly updated time together with a one-cycle tick. On that tick the unit compares every field. When all of them agree, it sets a sticky status flag.

The interrupt line is the status flag gated by the enable. Software clears the flag by writing a one to its bit in the status register. Bits written as zero leave the flag unchanged. The day of the week is not an input and takes no part in the comparison. Software is expected to disable the alarm before it rewrites the alarm bytes.

Top module: `cal_alarm_unit`

## Requirements
- R1: After a synchronous active-low reset, every alarm byte, the enable bit and the status flag read as zero, and `irq` is low.
- R2: The alarm bytes sit at addresses 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34 and 0x38, holding in that order seconds, minutes, hours, day, month, year-low and year-high. A write stores the data ANDed with the field mask 0x7F, 0x7F, 0x3F, 0x3F, 0x1F, 0xFF, 0xFF respectively, and a read returns the stored value.
- R3: The enable register is at 0x48 and keeps only bit 7, which arms the alarm. Writing 0xFF arms it and writing 0x00 disarms it. A read returns bit 7 with all other bits zero.
- R4: On a cycle with `tm_tick` high, the status flag is set at the next clock edge exactly when every calendar byte of `cal_bcd` (field i in bits 8i+7..8i, masked as in R2) equals its alarm byte. A mismatch in any single field leaves the flag clear.
- R5: While `tm_tick` is low the status flag is never set, even if the calendar equals the alarm.
- R6: The status register is at 0x40, with the alarm flag at bit 4 and the other bits reading zero. The flag stays set until software clears it.
- R7: A write to 0x40 clears the flag when bit 4 of the written data is one. A write with bit 4 zero leaves the flag set.
- R8: `irq` is high exactly when the flag is set and the alarm is armed. Disarming drops `irq` but keeps the flag, and re-arming raises `irq` again.
- R9: When a clearing write to 0x40 and a matching tick occur in the same cycle, the flag ends up set.
- R10: Reads of unmapped addresses return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tm_tick | input | 1 | One-cycle pulse when `cal_bcd` holds the newly updated time |
| cal_bcd | input | 56 | Running calendar, seven BCD bytes, seconds in the low byte |
| irq | output | 1 | Alarm interrupt |

## Verification
A register write or a tick that is present before a clock edge shows its effect right after that edge. Read data is combinational, so it reflects the new state in the same cycle. `irq` is likewise a gate of two registers and changes in the cycle after the write or tick that caused it. The bench applies inputs shortly after a rising edge and samples at the following falling edge. A behavioural model is updated at every rising edge from the same inputs, and both `reg_rdata` and `irq` are compared with it at every falling edge. The directed steps additionally check the status flag and `irq` in the first cycle after each tick, each clear and each change of the enable bit.

// File: rtl/cal_alarm_pkg.sv
// Shared constants for the calendar alarm unit: register map, widths,
// field count and the per-field storage masks.
// Assumes byte-wide registers on a word-spaced address map.
package cal_alarm_pkg;

    localparam int DATA_W       = 8;
    localparam int ADDR_W       = 8;
    localparam int FIELD_N      = 7;
    localparam int CAL_W        = FIELD_N * DATA_W;

    localparam int ALM_BASE     = 'h20;
    localparam int ALM_STRIDE   = 4;
    localparam int STATUS_ADDR  = 'h40;
    localparam int IEN_ADDR     = 'h48;

    localparam int STAT_ALM_BIT = 4;
    localparam int IEN_ALM_BIT  = 7;

    // Mask of the meaningful BCD bits of field idx (0 = seconds ... 6 = year-high)
    function automatic logic [DATA_W-1:0] field_mask(input int idx);
        case (idx)
            0, 1:    field_mask = 8'h7F;
            2, 3:    field_mask = 8'h3F;
            4:       field_mask = 8'h1F;
            default: field_mask = 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/alarm_regfile.sv
// Alarm byte store and enable register.
// Holds FIELD_N masked alarm bytes and the arm bit. It returns the read
// data for the field addresses and the enable address, and zero for any
// other address.
// Assumes single-cycle writes, with no byte enables.
module alarm_regfile
    import cal_alarm_pkg::*;
#(
    parameter int NF = FIELD_N,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [NF*DW-1:0] fields,
    output logic             alarm_en,
    output logic [DW-1:0]    rd_val
);

    localparam logic [AW-1:0] IEN_A = AW'(IEN_ADDR);

    logic [NF-1:0]    sel;
    logic [DW-1:0]    rd_part [NF];

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_fld
            localparam logic [AW-1:0] FA   = AW'(ALM_BASE + gi * ALM_STRIDE);
            localparam logic [DW-1:0] MSK  = field_mask(gi);
            logic [DW-1:0] q;

            assign sel[gi] = (addr == FA);

            // Store one masked alarm byte
            always_ff @(posedge clk) begin
                if (!rst_n)               q <= '0;
                else if (wr && sel[gi])   q <= wdata & MSK;
            end

            assign fields[gi*DW +: DW] = q;
            assign rd_part[gi]         = sel[gi] ? q : '0;
        end
    endgenerate

    // Arm bit of the enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                     alarm_en <= 1'b0;
        else if (wr && addr == IEN_A)   alarm_en <= wdata[IEN_ALM_BIT];
    end

    // Read mux over fields and the enable register
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NF; i++) rd_val = rd_val | rd_part[i];
        if (addr == IEN_A) rd_val[IEN_ALM_BIT] = alarm_en;
    end

endmodule

// File: rtl/alarm_matcher.sv
// Field comparator: reports a match when every masked calendar byte equals
// its stored alarm byte. Purely combinational.
// Assumes the stored alarm bytes are already masked.
module alarm_matcher
    import cal_alarm_pkg::*;
#(
    parameter int NF = FIELD_N,
    parameter int DW = DATA_W
) (
    input  logic [NF*DW-1:0] cal,
    input  logic [NF*DW-1:0] fields,
    output logic             match_all
);

    logic [NF-1:0] eq;

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_cmp
            localparam logic [DW-1:0] MSK = field_mask(gi);
            assign eq[gi] = ((cal[gi*DW +: DW] & MSK) == fields[gi*DW +: DW]);
        end
    endgenerate

    assign match_all = &eq;

endmodule

// File: rtl/alarm_status.sv
// Sticky alarm flag and interrupt gate.
// A matching tick sets the flag, and a clearing write drops it. The set
// takes priority when both occur in one cycle. The interrupt is the flag
// gated by the arm bit.
module alarm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match_all,
    input  logic clr_req,
    input  logic clr_bit,
    input  logic alarm_en,
    output logic status_q,
    output logic irq
);

    // Sticky flag, with set winning over clear
    always_ff @(posedge clk) begin
        if (!rst_n)                     status_q <= 1'b0;
        else if (tick && match_all)     status_q <= 1'b1;
        else if (clr_req && clr_bit)    status_q <= 1'b0;
    end

    // Interrupt gate
    assign irq = status_q & alarm_en;

endmodule

// File: rtl/cal_alarm_unit.sv
// Top of the calendar alarm unit: register port, field compare on the
// seconds tick, sticky status and interrupt output.
// Assumes cal_bcd is stable and valid in the cycle where tm_tick is high.
module cal_alarm_unit
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tm_tick,
    input  logic [CAL_W-1:0]  cal_bcd,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

    logic [CAL_W-1:0]  alarm_fields;
    logic              alarm_en;
    logic [DATA_W-1:0] fld_rd;
    logic              match_all;
    logic              alarm_status;
    logic              stat_sel;

    assign stat_sel = (reg_addr == STAT_A);

    alarm_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .fields   (alarm_fields),
        .alarm_en (alarm_en),
        .rd_val   (fld_rd)
    );

    alarm_matcher u_match (
        .cal       (cal_bcd),
        .fields    (alarm_fields),
        .match_all (match_all)
    );

    alarm_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tm_tick),
        .match_all (match_all),
        .clr_req   (reg_wr && stat_sel),
        .clr_bit   (reg_wdata[STAT_ALM_BIT]),
        .alarm_en  (alarm_en),
        .status_q  (alarm_status),
        .irq       (irq)
    );

    // Merge the status register into the read data
    always_comb begin
        reg_rdata = fld_rd;
        if (stat_sel) reg_rdata[STAT_ALM_BIT] = alarm_status;
    end

endmodule

// File: rtl/cal_alarm_checker.sv
// Temporal checks on the alarm unit, attached to the top by bind.
module cal_alarm_checker
    import cal_alarm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              hit,
    input logic              status,
    input logic              en,
    input logic              irq
);

    logic clr_w;
    logic dis_w;
    assign clr_w = wr && (addr == ADDR_W'(STATUS_ADDR)) && wdata[STAT_ALM_BIT];
    assign dis_w = wr && (addr == ADDR_W'(IEN_ADDR)) && !wdata[IEN_ALM_BIT];

    p_set_on_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit) |=> status);

    p_no_set_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!status && !tick) |=> !status);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr_w) |=> status);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status && clr_w && !(tick && hit)) |=> !status);

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status && en));

    p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dis_w |=> !irq);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && tick && hit) |=> status);

endmodule

bind cal_alarm_unit cal_alarm_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tm_tick),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .hit    (match_all),
    .status (alarm_status),
    .en     (alarm_en),
    .irq    (irq)
);

// File: tb/sim_cal_alarm_unit.sv
`timescale 1ns/1ps
module sim_cal_alarm_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        tm_tick = 1'b0;
    logic [55:0] cal_bcd = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cal_alarm_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tm_tick(tm_tick),
        .cal_bcd(cal_bcd), .irq(irq)
    );

    // Behavioural reference state
    logic [7:0] m_fld [7];
    logic       m_en;
    logic       m_st;

    function automatic logic [7:0] msk(input int i);
        if (i < 2) return 8'h7F;
        if (i < 4) return 8'h3F;
        if (i == 4) return 8'h1F;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] a);
        for (int i = 0; i < 7; i++) if (a == 8'(8'h20 + 4 * i)) return m_fld[i];
        if (a == 8'h40) return {3'b0, m_st, 4'b0};
        if (a == 8'h48) return {m_en, 7'b0};
        return 8'h00;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (a >= 8'h20 && a <= 8'h38 && a[1:0] == 2'b00) return "R2";
        if (a == 8'h40) return "R6";
        if (a == 8'h48) return "R3";
        return "R10";
    endfunction

    // Reference model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 7; i++) m_fld[i] = 8'h00;
            m_en = 1'b0;
            m_st = 1'b0;
        end else begin
            bit hit;
            hit = tm_tick;
            for (int i = 0; i < 7; i++)
                if ((cal_bcd[8*i +: 8] & msk(i)) != m_fld[i]) hit = 0;
            if (hit) m_st = 1'b1;
            else if (reg_wr && reg_addr == 8'h40 && reg_wdata[4]) m_st = 1'b0;
            if (reg_wr) begin
                for (int i = 0; i < 7; i++)
                    if (reg_addr == 8'(8'h20 + 4 * i)) m_fld[i] = reg_wdata & msk(i);
                if (reg_addr == 8'h48) m_en = reg_wdata[7];
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Continuous comparison against the model at each falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(reg_rdata, m_read(reg_addr), tag_of(reg_addr));
            chk({7'b0, irq}, {7'b0, m_st & m_en}, "R8");
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk);
        chk(reg_rdata, exp, tag);
    endtask

    task automatic pulse_tick(input logic [55:0] c);
        @(posedge clk); #2;
        cal_bcd = c; tm_tick = 1'b1;
        @(posedge clk); #2;
        tm_tick = 1'b0;
    endtask

    localparam logic [55:0] ALM = 56'h20_99_12_31_23_30_59;

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 7; i++) rd_chk(8'(8'h20 + 4 * i), 8'h00, "R1");
        rd_chk(8'h40, 8'h00, "R1");
        rd_chk(8'h48, 8'h00, "R1");
        chk({7'b0, irq}, 8'h00, "R1");

        // R2 masking on every field
        for (int i = 0; i < 7; i++) begin
            wr_reg(8'(8'h20 + 4 * i), 8'hFF);
            rd_chk(8'(8'h20 + 4 * i), msk(i), "R2");
        end
        for (int i = 0; i < 7; i++) wr_reg(8'(8'h20 + 4 * i), ALM[8*i +: 8]);
        rd_chk(8'h34, 8'h99, "R2");

        // R5 equal calendar without tick
        @(posedge clk); #2 cal_bcd = ALM;
        repeat (4) @(posedge clk);
        rd_chk(8'h40, 8'h00, "R5");

        // R4 one field off per tick
        for (int i = 0; i < 7; i++) begin
            logic [55:0] c;
            c = ALM;
            c[8*i +: 8] = c[8*i +: 8] ^ 8'h01;
            pulse_tick(c);
            rd_chk(8'h40, 8'h00, "R4");
        end
        // R4 match with stray bits above the field masks
        pulse_tick(ALM | 56'h00_00_E0_C0_C0_80_80);
        rd_chk(8'h40, 8'h10, "R4");
        chk({7'b0, irq}, 8'h00, "R8");

        // R3 and R8 arming and disarming
        wr_reg(8'h48, 8'hFF);
        rd_chk(8'h48, 8'h80, "R3");
        chk({7'b0, irq}, 8'h01, "R8");
        wr_reg(8'h48, 8'h00);
        chk({7'b0, irq}, 8'h00, "R8");
        rd_chk(8'h40, 8'h10, "R6");
        wr_reg(8'h48, 8'hFF);
        chk({7'b0, irq}, 8'h01, "R8");

        // R7 clear only with bit 4 set
        wr_reg(8'h40, 8'hEF);
        rd_chk(8'h40, 8'h10, "R7");
        wr_reg(8'h40, 8'h10);
        rd_chk(8'h40, 8'h00, "R7");
        chk({7'b0, irq}, 8'h00, "R7");

        // R9 clear and match in the same cycle
        @(posedge clk); #2;
        cal_bcd = ALM; tm_tick = 1'b1;
        reg_wr = 1'b1; reg_addr = 8'h40; reg_wdata = 8'hFF;
        @(posedge clk); #2;
        tm_tick = 1'b0; reg_wr = 1'b0;
        @(negedge clk);
        chk(reg_rdata, 8'h10, "R9");
        chk({7'b0, irq}, 8'h01, "R9");
        wr_reg(8'h40, 8'hFF);
        rd_chk(8'h40, 8'h00, "R7");

        // R10 unmapped addresses
        wr_reg(8'h3C, 8'hFF);
        wr_reg(8'h4C, 8'hFF);
        wr_reg(8'h21, 8'hFF);
        rd_chk(8'h3C, 8'h00, "R10");
        rd_chk(8'h4C, 8'h00, "R10");
        rd_chk(8'h21, 8'h00, "R10");
        rd_chk(8'h20, 8'h59, "R10");
        rd_chk(8'h48, 8'h80, "R10");

        repeat (2) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule